// File: doc/BRIEF.md
# Oscillator-Tracked Tap Delay Corrector

This block keeps a delay-line time-to-digital converter's per-tap time table accurate while supply voltage and die temperature wander. A free-running ring oscillator placed beside the delay line drifts in step with the line's cells. The block counts the oscillator's rising edges over a gate window of a programmable number of system clocks. When calibration finishes, it takes the next completed count as the reference. From then on it compares each new count with that reference. If the difference exceeds a programmable dead band, it recomputes every tap time as `base * reference / current` with one shared sequential divider. It writes the results into a shadow bank and then swaps banks in a single cycle.

The initial tap times come from a code-density calibration done elsewhere. They are loaded through a write port, and a one-cycle `cal_done` strobe marks the end of calibration. Lookups read the active bank with one cycle of latency and never see a table that is only partly rewritten. Status outputs expose the reference count, the latest count and a pass-busy flag.

The control state machine has five states:

| State | Role |
|---|---|
| IDLE | No reference exists yet. |
| ARM | Waiting for the measurement that becomes the reference. |
| TRACK | Monitoring each new count. |
| SCALE | Dividing one entry at a time. |
| SWAP | Flipping the active bank. |

Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→ARM | `cal_done` |
| ARM→TRACK | A measurement completes; its count is captured as the reference. |
| TRACK→ARM | `cal_done` (re-calibration). This takes priority over starting a pass. |
| TRACK→SCALE | A measurement completes, is nonzero and lies outside the dead band. |
| SCALE→SWAP | The last entry has been written. |
| SWAP→TRACK | Unconditional. |

`cal_done` is ignored in ARM, SCALE and SWAP.

Top module: `tap_drift_comp`

## Requirements
- R1: After reset, `st_ref`, `st_last`, `st_busy` and `lk_time` are all zero, and every table entry reads zero.
- R2: The oscillator input passes through two synchronizer flops. A rising edge of the second flop counts once. A window lasts `gate_len` clocks, and a value of 0 is treated as 1. At the clock edge that closes a window, `st_last` takes that window's count, which saturates at all ones.
- R3: After a `cal_done` strobe, the first measurement that completes becomes `st_ref`. At no other time does `st_ref` change.
- R4: A pass starts only in TRACK, when a measurement is nonzero and its absolute difference from `st_ref` is strictly greater than `deadband`. Otherwise the table is left unchanged.
- R5: After a pass, entry i reads floor(base_i × ref / cur), saturated at 2^TAP_W−1. Here base_i is the loaded value and cur is the count that triggered the pass.
- R6: While `st_busy` is high, lookups return the table as it stood before the pass. All entries change together at the swap.
- R7: `lk_time` shows the active entry addressed by `lk_idx` one clock after `lk_idx` is presented.
- R8: A write with `tap_we` high sets base entry `tap_widx` to `tap_wdata`, and that value is visible to lookups immediately.
- R9: A `cal_done` in TRACK re-arms the block. The next completed measurement replaces `st_ref` and does not start a pass.
- R10: Every pass runs TRACK→SCALE→SWAP→TRACK, and `st_busy` is high exactly in SCALE and SWAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Ring oscillator output, asynchronous |
| gate_len | input | GATE_W | Measurement window in clocks |
| deadband | input | CNT_W | Largest count difference that triggers no pass |
| cal_done | input | 1 | One-cycle strobe: calibration finished |
| tap_we | input | 1 | Base table write enable |
| tap_widx | input | IDX_W | Base table write index |
| tap_wdata | input | TAP_W | Base tap time |
| lk_idx | input | IDX_W | Lookup index |
| lk_time | output | TAP_W | Corrected tap time, one clock after `lk_idx` |
| st_ref | output | CNT_W | Reference count |
| st_last | output | CNT_W | Latest completed count |
| st_busy | output | 1 | Rescale pass in progress |

## Verification
| Result | Due |
|---|---|
| Rising oscillator edge | Enters the count three clock edges after the bench drives it. |
| `st_last` | Updates on the edge that closes the window. |
| `st_ref` | Updates one edge later, because the state machine reacts to the registered measurement pulse. |
| `lk_time` | Follows `lk_idx` after one edge. |

The bench drives `osc_in` and `cal_done` on falling edges, so its behavioural model sees exactly the values the design sampled. The model compares `st_ref` and `st_last` on every falling edge. Table contents are read only after `st_busy` has risen or fallen, and the expected values are computed from the count that triggered the pass.

// File: rtl/drift_pkg.sv
package drift_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ARM   = 3'd1,
        S_TRACK = 3'd2,
        S_SCALE = 3'd3,
        S_SWAP  = 3'd4
    } phase_t;
endpackage

// File: rtl/ring_freq_meter.sv
module ring_freq_meter #(
    parameter int CNT_W  = 16,
    parameter int GATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic [GATE_W-1:0] gate_len,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              valid_o
);
    logic [1:0]        sync_q;
    logic              prev_q;
    logic [GATE_W-1:0] tmr_q;
    logic [CNT_W-1:0]  acc_q;
    logic              rise;
    logic [CNT_W-1:0]  acc_nxt;
    logic              win_end;

    assign rise    = sync_q[1] & ~prev_q;
    assign acc_nxt = (rise && (acc_q != {CNT_W{1'b1}})) ? acc_q + 1'b1 : acc_q;
    assign win_end = ({1'b0, tmr_q} + 1'b1) >= {1'b0, gate_len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            prev_q  <= 1'b0;
            tmr_q   <= '0;
            acc_q   <= '0;
            cnt_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], osc_in};
            prev_q <= sync_q[1];
            if (win_end) begin
                cnt_o   <= acc_nxt;
                valid_o <= 1'b1;
                acc_q   <= '0;
                tmr_q   <= '0;
            end else begin
                acc_q   <= acc_nxt;
                tmr_q   <= tmr_q + 1'b1;
                valid_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [NUM_W-1:0]  q_q;
    logic [STEP_W-1:0] steps_q;
    logic [DEN_W:0]    rem_sh;
    logic              fits;

    assign rem_sh = {rem_q, q_q[NUM_W-1]};
    assign fits   = rem_sh >= {1'b0, den_q};
    assign busy   = steps_q != '0;
    assign quot   = q_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            den_q   <= '0;
            q_q     <= '0;
            steps_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                rem_q   <= '0;
                den_q   <= den;
                q_q     <= num;
                steps_q <= STEP_W'(NUM_W);
            end else if (busy) begin
                if (fits) begin
                    rem_q <= DEN_W'(rem_sh - {1'b0, den_q});
                end else begin
                    rem_q <= rem_sh[DEN_W-1:0];
                end
                q_q     <= {q_q[NUM_W-2:0], fits};
                steps_q <= steps_q - 1'b1;
                done    <= steps_q == STEP_W'(1);
            end
        end
    end
endmodule

// File: rtl/tap_bank.sv
module tap_bank #(
    parameter int N_TAPS = 16,
    parameter int TAP_W  = 16,
    localparam int IDX_W = $clog2(N_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAP_W-1:0] wr_val,
    input  logic             sh_we,
    input  logic [IDX_W-1:0] sh_idx,
    input  logic [TAP_W-1:0] sh_val,
    input  logic             swap,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAP_W-1:0] rd_val,
    input  logic [IDX_W-1:0] base_idx,
    output logic [TAP_W-1:0] base_val,
    output logic             act_o
);
    logic [TAP_W-1:0] base_q [N_TAPS];
    logic [TAP_W-1:0] bank_q [2][N_TAPS];
    logic             act_q;

    assign base_val = base_q[base_idx];
    assign act_o    = act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TAPS; i++) begin
                base_q[i]    <= '0;
                bank_q[0][i] <= '0;
                bank_q[1][i] <= '0;
            end
            act_q  <= 1'b0;
            rd_val <= '0;
        end else begin
            if (sh_we) begin
                bank_q[~act_q][sh_idx] <= sh_val;
            end
            if (wr_en) begin
                base_q[wr_idx]    <= wr_val;
                bank_q[0][wr_idx] <= wr_val;
                bank_q[1][wr_idx] <= wr_val;
            end
            if (swap) begin
                act_q <= ~act_q;
            end
            rd_val <= bank_q[act_q][rd_idx];
        end
    end
endmodule

// File: rtl/tap_drift_comp.sv
module tap_drift_comp
    import drift_pkg::*;
#(
    parameter int N_TAPS = 16,
    parameter int TAP_W  = 16,
    parameter int CNT_W  = 16,
    parameter int GATE_W = 16,
    localparam int IDX_W = $clog2(N_TAPS),
    localparam int NUM_W = TAP_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic [GATE_W-1:0] gate_len,
    input  logic [CNT_W-1:0]  deadband,
    input  logic              cal_done,
    input  logic              tap_we,
    input  logic [IDX_W-1:0]  tap_widx,
    input  logic [TAP_W-1:0]  tap_wdata,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [TAP_W-1:0]  lk_time,
    output logic [CNT_W-1:0]  st_ref,
    output logic [CNT_W-1:0]  st_last,
    output logic              st_busy
);
    phase_t            state_q, state_d;
    logic [CNT_W-1:0]  meas_cnt;
    logic              meas_valid;
    logic [CNT_W-1:0]  ref_q;
    logic [CNT_W-1:0]  cur_q;
    logic [IDX_W-1:0]  idx_q;
    logic              issued_q;
    logic [CNT_W-1:0]  gap;
    logic              over;
    logic              trigger;
    logic              div_start;
    logic              div_busy;
    logic              div_done;
    logic [NUM_W-1:0]  div_num;
    logic [NUM_W-1:0]  div_quot;
    logic [TAP_W-1:0]  base_val;
    logic [TAP_W-1:0]  scaled;
    logic              sh_we;
    logic              swap;
    logic              act_sel;
    logic              last_entry;

    ring_freq_meter #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .gate_len(gate_len),
        .cnt_o(meas_cnt), .valid_o(meas_valid)
    );

    assign gap     = (meas_cnt > ref_q) ? meas_cnt - ref_q : ref_q - meas_cnt;
    assign over    = gap > deadband;
    assign trigger = meas_valid && over && (meas_cnt != '0);

    assign last_entry = idx_q == IDX_W'(N_TAPS - 1);
    assign div_num    = NUM_W'(base_val) * NUM_W'(ref_q);
    assign div_start  = (state_q == S_SCALE) && !issued_q && !div_busy;
    assign scaled     = (div_quot[NUM_W-1:TAP_W] != '0) ? {TAP_W{1'b1}} : div_quot[TAP_W-1:0];
    assign sh_we      = (state_q == S_SCALE) && div_done;
    assign swap       = state_q == S_SWAP;

    seq_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(cur_q),
        .busy(div_busy), .done(div_done), .quot(div_quot)
    );

    tap_bank #(.N_TAPS(N_TAPS), .TAP_W(TAP_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tap_we), .wr_idx(tap_widx), .wr_val(tap_wdata),
        .sh_we(sh_we), .sh_idx(idx_q), .sh_val(scaled), .swap(swap),
        .rd_idx(lk_idx), .rd_val(lk_time),
        .base_idx(idx_q), .base_val(base_val), .act_o(act_sel)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cal_done) state_d = S_ARM;
            S_ARM:   if (meas_valid) state_d = S_TRACK;
            S_TRACK: begin
                if (cal_done)     state_d = S_ARM;
                else if (trigger) state_d = S_SCALE;
            end
            S_SCALE: if (div_done && last_entry) state_d = S_SWAP;
            S_SWAP:  state_d = S_TRACK;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q    <= '0;
            cur_q    <= '0;
            idx_q    <= '0;
            issued_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_ARM: if (meas_valid) ref_q <= meas_cnt;
                S_TRACK: begin
                    idx_q    <= '0;
                    issued_q <= 1'b0;
                    if (!cal_done && trigger) cur_q <= meas_cnt;
                end
                S_SCALE: begin
                    if (div_start) issued_q <= 1'b1;
                    if (div_done) begin
                        issued_q <= 1'b0;
                        if (!last_entry) idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign st_ref  = ref_q;
    assign st_last = meas_cnt;
    assign st_busy = (state_q == S_SCALE) || (state_q == S_SWAP);
endmodule

module tap_drift_comp_chk
    import drift_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input phase_t           state,
    input logic             cal_done,
    input logic             meas_valid,
    input logic             over,
    input logic [CNT_W-1:0] meas_cnt,
    input logic [CNT_W-1:0] st_ref,
    input logic             act_sel,
    input logic             div_start,
    input logic [CNT_W-1:0] div_den,
    input logic             st_busy
);
    // R3: reference moves only out of ARM
    a_r3_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_ARM) |=> $stable(st_ref));
    // R6: active bank holds until the swap state
    a_r6_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_SWAP) |=> $stable(act_sel));
    // R5: no division by zero
    a_r5_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> (div_den != '0));
    // R10: swap lasts one cycle and returns to tracking
    a_r10_swap_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SWAP) |=> (state == S_TRACK) && !st_busy);
    // R4: out-of-band count in TRACK starts a pass
    a_r4_pass_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRACK && !cal_done && meas_valid && over && meas_cnt != '0)
        |=> (state == S_SCALE) && st_busy);
    // R9: a measurement taken while armed never starts a pass
    a_r9_arm_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARM) |=> (state != S_SCALE));
endmodule

bind tap_drift_comp tap_drift_comp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .cal_done(cal_done),
    .meas_valid(meas_valid), .over(over), .meas_cnt(meas_cnt), .st_ref(st_ref),
    .act_sel(act_sel), .div_start(div_start), .div_den(cur_q), .st_busy(st_busy)
);

// File: tb/tap_drift_comp_tb.sv
module tap_drift_comp_tb;
    localparam int N_TAPS = 8;
    localparam int TAP_W  = 16;
    localparam int CNT_W  = 12;
    localparam int GATE_W = 12;
    localparam int IDX_W  = $clog2(N_TAPS);
    localparam int GATE   = 400;
    localparam int MAXT   = (1 << TAP_W) - 1;
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              osc_in = 1'b0;
    logic [GATE_W-1:0] gate_len = GATE_W'(GATE);
    logic [CNT_W-1:0]  deadband = CNT_W'(3);
    logic              cal_done = 1'b0;
    logic              tap_we = 1'b0;
    logic [IDX_W-1:0]  tap_widx = '0;
    logic [TAP_W-1:0]  tap_wdata = '0;
    logic [IDX_W-1:0]  lk_idx = '0;
    logic [TAP_W-1:0]  lk_time;
    logic [CNT_W-1:0]  st_ref;
    logic [CNT_W-1:0]  st_last;
    logic              st_busy;

    tap_drift_comp #(.N_TAPS(N_TAPS), .TAP_W(TAP_W), .CNT_W(CNT_W), .GATE_W(GATE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .gate_len(gate_len),
        .deadband(deadband), .cal_done(cal_done), .tap_we(tap_we),
        .tap_widx(tap_widx), .tap_wdata(tap_wdata), .lk_idx(lk_idx),
        .lk_time(lk_time), .st_ref(st_ref), .st_last(st_last), .st_busy(st_busy)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done_flag = 0;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    int  osc_half = 5;
    int  osc_ph = 0;
    bit  cal_req = 0;
    bit  rst_q = 0;
    int  m_s0, m_s1, m_prev, m_tmr, m_cnt, m_last, m_mv, m_ref, m_st; // m_st: 0 idle,1 arm,2 track
    int  base [N_TAPS];
    bit  busy_seen = 0;

    always @(posedge clk) rst_q <= rst_n;
    always @(posedge clk) if (st_busy) busy_seen <= 1'b1;

    always @(negedge clk) begin
        if (!rst_q) begin
            m_s0 = 0; m_s1 = 0; m_prev = 0; m_tmr = 0; m_cnt = 0;
            m_last = 0; m_mv = 0; m_ref = 0; m_st = 0;
        end else begin
            // control uses values held before this edge
            if (m_st == 0 && cal_done) m_st = 1;
            else if (m_st == 1 && m_mv == 1) begin m_ref = m_last; m_st = 2; end
            else if (m_st == 2 && cal_done) m_st = 1;
            // measurement (R2)
            begin
                int rise;
                rise = (m_s1 == 1 && m_prev == 0) ? 1 : 0;
                if (rise == 1 && m_cnt != MAXC) m_cnt = m_cnt + 1;
                if (m_tmr + 1 >= GATE) begin
                    m_last = m_cnt; m_mv = 1; m_cnt = 0; m_tmr = 0;
                end else begin
                    m_tmr = m_tmr + 1; m_mv = 0;
                end
                m_prev = m_s1; m_s1 = m_s0; m_s0 = int'(osc_in);
            end
            chk("R2 st_last", int'(st_last), m_last);
            chk("R3 st_ref", int'(st_ref), m_ref);
        end
        // drive next stimulus
        cal_done = cal_req;
        cal_req = 0;
        osc_ph++;
        if (osc_ph >= osc_half) begin osc_ph = 0; osc_in = ~osc_in; end
    end

    task automatic write_tap(input int i, input int v);
        @(negedge clk);
        tap_we = 1'b1; tap_widx = IDX_W'(i); tap_wdata = TAP_W'(v);
        @(negedge clk);
        tap_we = 1'b0;
    endtask

    task automatic read_tap(input int i, output int v);
        @(negedge clk);
        lk_idx = IDX_W'(i);
        @(negedge clk);
        v = int'(lk_time);
    endtask

    task automatic wait_busy(input bit lvl);
        int n = 0;
        while (st_busy !== lvl && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int scale_of(input int b, input int r, input int c);
        longint q;
        q = (longint'(b) * r) / c;
        return (q > MAXT) ? MAXT : int'(q);
    endfunction

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_flag) begin
            done_flag = 1;
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v, cur, ref0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 st_ref", int'(st_ref), 0);
        chk("R1 st_last", int'(st_last), 0);
        chk("R1 st_busy", int'(st_busy), 0);
        for (int i = 0; i < N_TAPS; i++) begin
            read_tap(i, v);
            chk("R1 table zero", v, 0);
        end
        // R8 load and immediate visibility, R7 latency
        for (int i = 0; i < N_TAPS; i++) begin
            base[i] = (i == N_TAPS - 1) ? 60000 : 1000 + i * 1500;
            write_tap(i, base[i]);
        end
        for (int i = 0; i < N_TAPS; i++) begin
            read_tap(i, v);
            chk("R8/R7 loaded tap", v, base[i]);
        end
        // R3 reference capture
        @(posedge clk); cal_req = 1;
        wait_cycles(2 * GATE + 20);
        chk("R3 reference 40", int'(st_ref), 40);
        chk("R4 no pass at reference", int'(busy_seen), 0);
        // R4 drift inside dead band
        deadband = CNT_W'(12);
        osc_half = 4;
        wait_cycles(3 * GATE);
        chk("R4 dead band blocks pass", int'(busy_seen), 0);
        chk("R2 count 50", int'(st_last), 50);
        for (int i = 0; i < N_TAPS; i++) begin
            read_tap(i, v);
            chk("R4 table unchanged", v, base[i]);
        end
        // R10 pass start, R6 atomic view
        ref0 = m_ref;
        deadband = CNT_W'(3);
        wait_busy(1'b1);
        chk("R10 busy rises", int'(st_busy), 1);
        cur = m_last;
        for (int i = 0; i < 4; i++) begin
            read_tap(i, v);
            if (st_busy) chk("R6 old table during pass", v, base[i]);
        end
        wait_busy(1'b0);
        chk("R10 busy falls", int'(st_busy), 0);
        for (int i = 0; i < N_TAPS; i++) begin
            read_tap(i, v);
            chk("R5 scaled tap", v, scale_of(base[i], ref0, cur));
        end
        // R5 saturation with a slower oscillator
        osc_half = 6;
        cur = 50;
        for (int k = 0; k < 6 && cur > 34; k++) begin
            wait_busy(1'b0);
            wait_busy(1'b1);
            cur = m_last;
            wait_busy(1'b0);
        end
        chk("R5 slow count", (cur <= 34) ? 1 : 0, 1);
        read_tap(N_TAPS - 1, v);
        chk("R5 saturated tap", v, MAXT);
        read_tap(1, v);
        chk("R5 grown tap", v, scale_of(base[1], ref0, cur));
        // R9 re-calibration
        wait_busy(1'b0);
        @(posedge clk); cal_req = 1;
        wait_cycles(GATE + 30);
        wait_busy(1'b0);
        wait_cycles(GATE + 30);
        chk("R9 new reference", (st_ref >= 33 && st_ref <= 34) ? 1 : 0, 1);
        busy_seen = 0;
        wait_cycles(2 * GATE);
        chk("R9 no pass after rearm", int'(busy_seen), 0);
        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule